// File: doc/BRIEF.md
# Dual Prescaled Down-Counter Timer

Two timer channels, each built from a 6-bit prescaler down counter that feeds an 8-bit down counter. Both stages of a channel load from initial values that software writes over a simple register bus. Software reads the 8-bit count through the same bus. When a channel reaches terminal count it raises a one-cycle interrupt pulse. It then either stops (single pass) or reloads and continues (continuous).

Channel 0 decrements its prescaler on every clock while it runs. Channel 1 has three possible count sources: a free-running divide-by-four reference, an external input pin, or the terminal-count pulse of channel 0 (cascade). The pin passes through a two-flop synchroniser with falling-edge detection. It can act as a count clock, as a gate on the reference, or as a start trigger, which is either retriggerable or not. A shared output pin can toggle on either channel's terminal count, or carry the divide-by-four reference.

Top module: `dual_prescaled_timer`

## Requirements
- R1: After reset both counts read 0, both interrupts are low and the output pin is low.
- R2: A channel with prescaler value P and count value N signals terminal count after P*N ticks. A prescaler value of 0 counts as 64 and a count value of 0 counts as 256. Channel 0 ticks on every clock edge while it runs.
- R3: In single pass (bit 6 of the prescaler register is 0), the channel stops at terminal count. Its count then reads 0 and stays there, and no further interrupt follows.
- R4: In continuous mode (bit 6 = 1), both stages reload at terminal count and the interrupt repeats every P*N ticks.
- R5: A write to the control register (address 4) sets each channel's run bit from bit 1 (channel 0) or bit 3 (channel 1). The same write reloads both initial values where bit 0 (channel 0) or bit 2 (channel 1) is set. Clearing the run bit freezes the count. Setting it alone resumes from the frozen value. Setting both bits restarts from the initial value.
- R6: Read address 0 returns the count of channel 0 and read address 1 returns the count of channel 1, combinationally. Reads never alter a count.
- R7: With mode bit 2 clear and mode bit 3 clear, channel 1 ticks at the clock edges where a 2-bit counter, free-running since reset, holds 3. These are the 4th, 8th, and later edges after reset is released.
- R8: External clock mode (mode bits [1:0] = 00, bit 2 set): each falling edge of the pin produces one tick, at the third rising clock edge after the pin falls.
- R9: Gate mode (01): channel 1 ticks on the divide-by-four edges only while the synchronised pin is high. With the pin low the count holds.
- R10: Single trigger mode (10): while armed (run bit set), a pin falling edge loads the initial values and starts counting on the divide-by-four edges. Edges arriving during a count are ignored. After a single pass the channel stays armed for the next edge.
- R11: Retriggerable mode (11): every pin falling edge reloads the initial values, three clock edges after the fall, and restarts the count.
- R12: With mode bit 3 set, channel 1 ticks once on each channel 0 terminal count, whatever bit 2 holds.
- R13: Each interrupt is high for exactly the one cycle following the clock edge at which its channel reaches terminal count.
- R14: Mode bits [5:4] select the output pin: 00 holds it low, 01 and 10 toggle it on each terminal count of channel 0 and channel 1 respectively, and 11 drives the divide-by-four reference (two cycles high, two cycles low).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address: 0/2 prescaler+mode bit for channel 0/1, 1/3 count value, 4 control, 5 mode |
| wr_data | input | 8 | Write data |
| rd_addr | input | 3 | Read address: 0 count 0, 1 count 1, 5 mode |
| rd_data | output | 8 | Combinational read data |
| tin | input | 1 | External count/gate/trigger pin, asynchronous |
| irq0 | output | 1 | Channel 0 terminal-count pulse |
| irq1 | output | 1 | Channel 1 terminal-count pulse |
| tout | output | 1 | Shared timer output pin |

## Verification
If a start write lands on edge W, channel 0's interrupt follows in the cycle after edge W+P*N. Channel 1's interrupt falls on the P*N-th divide-by-four edge after W, or after the edge that applies a trigger load. A pin event takes three edges to become a tick or a load. The bench computes each interrupt edge from these counts and queues it before the event can occur. A monitor samples on the falling clock edge and compares each pulse against the head of the queue, so an early, late, missing or extra pulse is reported. Counts and the output pin are read half a cycle after the edge that settles them.

// File: rtl/dpt_pkg.sv
package dpt_pkg;
  typedef enum logic [1:0] {
    EXT_CLOCK       = 2'd0,
    EXT_GATE        = 2'd1,
    EXT_TRIG_ONCE   = 2'd2,
    EXT_TRIG_RETRIG = 2'd3
  } ext_mode_e;

  typedef enum logic [1:0] {
    OUT_OFF = 2'd0,
    OUT_CH0 = 2'd1,
    OUT_CH1 = 2'd2,
    OUT_REF = 2'd3
  } out_sel_e;

  typedef struct packed {
    out_sel_e  sel;
    logic      cascade;
    logic      src_ext;
    ext_mode_e ext;
  } mode_t;

  localparam int ADDR_CTRL = 4;
  localparam int ADDR_MODE = 5;
  localparam int RD_CNT0   = 0;
  localparam int RD_CNT1   = 1;
endpackage

// File: rtl/dpt_sync_edge.sv
module dpt_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic level,
  output logic fall
);
  logic [STAGES:0] sh_q, sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-1:0], pin};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '1;
    else        sh_q <= sh_d;
  end

  assign level = sh_q[STAGES-1];
  assign fall  = sh_q[STAGES] & ~sh_q[STAGES-1];

  // R8
  single_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fall |=> !fall);
endmodule

// File: rtl/dpt_chan.sv
module dpt_chan #(
  parameter int PRE_W = 6,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld,
  input  logic             tick,
  input  logic             cont,
  input  logic [PRE_W-1:0] pre_init,
  input  logic [CNT_W-1:0] cnt_init,
  output logic [CNT_W-1:0] cnt,
  output logic             tc
);
  localparam logic [PRE_W-1:0] PRE_ONE = PRE_W'(1);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [PRE_W-1:0] pre_q, pre_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             pre_end, cnt_end;

  assign pre_end = (pre_q == PRE_ONE);
  assign cnt_end = (cnt_q == CNT_ONE);
  assign tc      = tick & ~ld & pre_end & cnt_end;

  always_comb begin
    pre_d = pre_q;
    cnt_d = cnt_q;
    if (ld) begin
      pre_d = pre_init;
      cnt_d = cnt_init;
    end else if (tick) begin
      if (pre_end) begin
        pre_d = pre_init;
        if (cnt_end) cnt_d = cont ? cnt_init : '0;
        else         cnt_d = cnt_q - CNT_ONE;
      end else begin
        pre_d = pre_q - PRE_ONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      cnt_q <= '0;
    end else begin
      pre_q <= pre_d;
      cnt_q <= cnt_d;
    end
  end

  assign cnt = cnt_q;

  // R2
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !ld && pre_end && !cnt_end) |=> (cnt_q == ($past(cnt_q) - CNT_ONE)));

  // R6
  hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !ld) |=> ($stable(cnt_q) && $stable(pre_q)));
endmodule

// File: rtl/dpt_t1_src.sv
module dpt_t1_src
  import dpt_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      run,
  input  logic      cascade,
  input  logic      src_ext,
  input  ext_mode_e ext,
  input  logic      div_tick,
  input  logic      fall,
  input  logic      level,
  input  logic      t0_tc,
  input  logic      tc_self,
  input  logic      cont,
  output logic      tick,
  output logic      trig_load,
  output logic      trig_mode
);
  logic active_q, active_d;

  assign trig_mode = src_ext & ~cascade & ext[1];
  assign trig_load = trig_mode & run & fall &
                     ((ext == EXT_TRIG_RETRIG) | ~active_q);

  always_comb begin
    active_d = active_q;
    if (!trig_mode || !run)   active_d = 1'b0;
    else if (trig_load)       active_d = 1'b1;
    else if (tc_self && !cont) active_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) active_q <= 1'b0;
    else        active_q <= active_d;
  end

  always_comb begin
    tick = 1'b0;
    if (run) begin
      if (cascade)       tick = t0_tc;
      else if (!src_ext) tick = div_tick;
      else begin
        case (ext)
          EXT_CLOCK: tick = fall;
          EXT_GATE:  tick = div_tick & level;
          default:   tick = active_q & div_tick & ~trig_load;
        endcase
      end
    end
  end
endmodule

// File: rtl/dual_prescaled_timer.sv
module dual_prescaled_timer
  import dpt_pkg::*;
#(
  parameter int PRE_W       = 6,
  parameter int CNT_W       = 8,
  parameter int DATA_W      = 8,
  parameter int ADDR_W      = 3,
  parameter int SYNC_STAGES = 2,
  parameter int DIV_W       = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              tin,
  output logic              irq0,
  output logic              irq1,
  output logic              tout
);
  localparam int NCH    = 2;
  localparam int MODE_W = $bits(mode_t);

  logic             ctrl_wr, mode_wr;
  mode_t            mode_q, mode_d;
  logic [NCH-1:0]   run_q, run_d, sw_ld, ld_v, tick_v, tc_v, irq_q, stop_ok, cont_q;
  logic [PRE_W-1:0] pre_init_q [NCH];
  logic [CNT_W-1:0] cnt_init_q [NCH];
  logic [CNT_W-1:0] cnt_v      [NCH];
  logic [DIV_W-1:0] div_q, div_d;
  logic             div_tick, ext_level, ext_fall, trig_load1, trig1;
  logic             tog_q, tog_d, tc_sel;

  assign ctrl_wr = wr_en && (wr_addr == ADDR_W'(ADDR_CTRL));
  assign mode_wr = wr_en && (wr_addr == ADDR_W'(ADDR_MODE));

  // divide-by-four reference
  assign div_d    = div_q + DIV_W'(1);
  assign div_tick = &div_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_d;
  end

  // mode register
  assign mode_d = mode_wr ? mode_t'(wr_data[MODE_W-1:0]) : mode_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= '0;
    else        mode_q <= mode_d;
  end

  dpt_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .pin   (tin),
    .level (ext_level),
    .fall  (ext_fall)
  );

  assign stop_ok = {~trig1, 1'b1};

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic             pre_wr, cnt_wr;
    logic [PRE_W-1:0] pre_init_d;
    logic [CNT_W-1:0] cnt_init_d;
    logic             cont_d;

    assign pre_wr = wr_en && (wr_addr == ADDR_W'(2 * i));
    assign cnt_wr = wr_en && (wr_addr == ADDR_W'(2 * i + 1));
    assign sw_ld[i] = ctrl_wr & wr_data[2 * i];

    always_comb begin
      pre_init_d = pre_wr ? wr_data[PRE_W-1:0] : pre_init_q[i];
      cont_d     = pre_wr ? wr_data[PRE_W]     : cont_q[i];
      cnt_init_d = cnt_wr ? wr_data[CNT_W-1:0] : cnt_init_q[i];
      run_d[i]   = run_q[i];
      if (ctrl_wr)                                  run_d[i] = wr_data[2 * i + 1];
      else if (tc_v[i] && !cont_q[i] && stop_ok[i]) run_d[i] = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pre_init_q[i] <= '0;
        cnt_init_q[i] <= '0;
        cont_q[i]     <= 1'b0;
        run_q[i]      <= 1'b0;
        irq_q[i]      <= 1'b0;
      end else begin
        pre_init_q[i] <= pre_init_d;
        cnt_init_q[i] <= cnt_init_d;
        cont_q[i]     <= cont_d;
        run_q[i]      <= run_d[i];
        irq_q[i]      <= tc_v[i];
      end
    end

    dpt_chan #(.PRE_W(PRE_W), .CNT_W(CNT_W)) u_chan (
      .clk      (clk),
      .rst_n    (rst_n),
      .ld       (ld_v[i]),
      .tick     (tick_v[i]),
      .cont     (cont_q[i]),
      .pre_init (pre_init_q[i]),
      .cnt_init (cnt_init_q[i]),
      .cnt      (cnt_v[i]),
      .tc       (tc_v[i])
    );

    // R3
    single_pass_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tc_v[i] && !cont_q[i] && stop_ok[i] && !ctrl_wr) |=> (!run_q[i] && cnt_v[i] == '0));

    // R5, R11
    load_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ld_v[i] |=> (cnt_v[i] == $past(cnt_init_q[i])));
  end

  dpt_t1_src u_t1_src (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run_q[1]),
    .cascade   (mode_q.cascade),
    .src_ext   (mode_q.src_ext),
    .ext       (mode_q.ext),
    .div_tick  (div_tick),
    .fall      (ext_fall),
    .level     (ext_level),
    .t0_tc     (tc_v[0]),
    .tc_self   (tc_v[1]),
    .cont      (cont_q[1]),
    .tick      (tick_v[1]),
    .trig_load (trig_load1),
    .trig_mode (trig1)
  );

  assign tick_v[0] = run_q[0];
  assign ld_v[0]   = sw_ld[0];
  assign ld_v[1]   = sw_ld[1] | trig_load1;

  // output pin
  always_comb begin
    case (mode_q.sel)
      OUT_CH0: tc_sel = tc_v[0];
      OUT_CH1: tc_sel = tc_v[1];
      default: tc_sel = 1'b0;
    endcase
    tog_d = tog_q ^ tc_sel;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tog_q <= 1'b0;
    else        tog_q <= tog_d;
  end

  always_comb begin
    case (mode_q.sel)
      OUT_OFF: tout = 1'b0;
      OUT_REF: tout = div_q[DIV_W-1];
      default: tout = tog_q;
    endcase
  end

  assign irq0 = irq_q[0];
  assign irq1 = irq_q[1];

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      ADDR_W'(RD_CNT0):   rd_data = DATA_W'(cnt_v[0]);
      ADDR_W'(RD_CNT1):   rd_data = DATA_W'(cnt_v[1]);
      ADDR_W'(ADDR_MODE): rd_data = DATA_W'(mode_q);
      default:            rd_data = '0;
    endcase
  end

  // R14
  tout_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q.sel == OUT_CH0 && tc_v[0] && !mode_wr) |=> (tout != $past(tout)));
endmodule

// File: tb/dual_prescaled_timer_bench.sv
module dual_prescaled_timer_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en;
  logic [2:0] wr_addr;
  logic [7:0] wr_data;
  logic [2:0] rd_addr;
  logic [7:0] rd_data;
  logic       tin;
  logic       irq0, irq1, tout;

  typedef struct {
    int    cyc;
    string tag;
  } exp_t;

  exp_t q0[$];
  exp_t q1[$];
  int   cyc = 0;
  int   rel = 0;
  int   last_wr = 0;
  int   n_run = 0;
  int   n_fail = 0;
  bit   done = 1'b0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  dual_prescaled_timer u_dual_prescaled_timer (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .tin(tin), .irq0(irq0), .irq1(irq1), .tout(tout)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic push(input int ch, input int c, input string tag);
    exp_t e;
    e.cyc = c;
    e.tag = tag;
    if (ch == 0) q0.push_back(e);
    else         q1.push_back(e);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    exp_t e;
    if (rst_n === 1'b1 && !done) begin
      if (irq0) begin
        if (q0.size() == 0) chk(1'b0, "R13 unexpected irq0", cyc, -1);
        else begin
          e = q0.pop_front();
          chk(cyc == e.cyc, {e.tag, " irq0 cycle"}, cyc, e.cyc);
        end
      end
      if (irq1) begin
        if (q1.size() == 0) chk(1'b0, "R13 unexpected irq1", cyc, -1);
        else begin
          e = q1.pop_front();
          chk(cyc == e.cyc, {e.tag, " irq1 cycle"}, cyc, e.cyc);
        end
      end
    end
  end

  task automatic finish_run();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    finish_run();
  end

  task automatic wr(input int a, input int d);
    wr_addr = 3'(a);
    wr_data = 8'(d);
    wr_en   = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wr_en   = 1'b0;
    last_wr = cyc;
  endtask

  task automatic rd(input int a, output int v);
    rd_addr = 3'(a);
    #1;
    v = int'(rd_data);
  endtask

  task automatic wait_until(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  function automatic int nth4(input int after, input int k);
    int c = after;
    int n = 0;
    while (n < k) begin
      c++;
      if (((c - rel) % 4) == 0) n++;
    end
    return c;
  endfunction

  initial begin
    int v, cw, cr, c0, c1, e1, e2, highs;
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0; tin = 1'b1;
    repeat (3) @(negedge clk);
    rd(0, v); chk(v == 0, "R1 count0 in reset", v, 0);
    chk(irq0 == 1'b0 && irq1 == 1'b0, "R1 irqs low", int'(irq0 | irq1), 0);
    chk(tout == 1'b0, "R1 tout low", int'(tout), 0);
    rst_n = 1'b1;
    rel = cyc;
    rd(1, v); chk(v == 0, "R1 count1 after reset", v, 0);

    // channel 0 single pass, P=2 N=3, output on T0
    wr(5, 8'h10);
    wr(0, 8'h02); wr(1, 3); wr(4, 8'h03); cw = last_wr;
    push(0, cw + 6, "R2");
    wait_until(cw + 6);
    chk(tout == 1'b1, "R14 tout toggled on T0", int'(tout), 1);
    repeat (10) @(negedge clk);
    rd(0, v); chk(v == 0, "R3 count holds 0 after single pass", v, 0);

    // continuous P=1 N=4, reads during count
    wr(0, 8'h41); wr(1, 4); wr(4, 8'h03); cw = last_wr;
    push(0, cw + 4, "R4"); push(0, cw + 8, "R4"); push(0, cw + 12, "R4");
    rd(0, v); chk(v == 4, "R6 count after load", v, 4);
    wait_until(cw + 1);
    rd(0, v); chk(v == 3, "R6 first read", v, 3);
    rd(0, v); chk(v == 3, "R6 repeat read undisturbed", v, 3);
    wait_until(cw + 12);
    chk(tout == 1'b0, "R14 tout after three toggles", int'(tout), 0);
    wr(4, 0);
    rd(0, v); chk(v == 3, "R5 stop freezes count", v, 3);

    // stop and resume, P=1 N=10 single
    wr(0, 8'h01); wr(1, 10); wr(4, 8'h03); cw = last_wr;
    wait_until(cw + 3);
    wr(4, 0);
    rd(0, v); chk(v == 6, "R5 count at stop", v, 6);
    repeat (10) @(negedge clk);
    rd(0, v); chk(v == 6, "R5 count held while stopped", v, 6);
    wr(4, 8'h02); cr = last_wr;
    push(0, cr + 6, "R5 resume");
    wait_until(cr + 8);

    // restart from initial value
    wr(4, 8'h03); cw = last_wr;
    wait_until(cw + 5);
    wr(4, 8'h03); cr = last_wr;
    rd(0, v); chk(v == 10, "R5 restart reloads", v, 10);
    push(0, cr + 10, "R5 restart");
    wait_until(cr + 12);

    // zero initial values
    wr(0, 8'h00); wr(1, 1); wr(4, 8'h03); cw = last_wr;
    push(0, cw + 64, "R2 prescaler 0 as 64");
    wait_until(cw + 66);
    wr(0, 8'h41); wr(1, 0); wr(4, 8'h03); cw = last_wr;
    push(0, cw + 256, "R4 count 0 as 256"); push(0, cw + 512, "R4 count 0 as 256");
    wait_until(cw + 512);
    wr(4, 0);
    rd(0, v); chk(v == 255, "R4 wrap after reload of 0", v, 255);

    // channel 1 on divide-by-four reference, P=2 N=2 continuous
    wr(5, 8'h20);
    wr(2, 8'h42); wr(3, 2); wr(4, 8'h0C); cw = last_wr;
    e1 = nth4(cw, 4); e2 = nth4(cw, 8);
    push(1, e1, "R7"); push(1, e2, "R7");
    wait_until(e2);
    wr(4, 0);

    // external clock, P=1 N=2 single
    wr(5, 8'h04);
    wr(2, 8'h01); wr(3, 2); wr(4, 8'h0C);
    c0 = cyc;
    tin = 1'b0;
    push(1, c0 + 7, "R8");
    wait_until(c0 + 2); tin = 1'b1;
    wait_until(c0 + 4); tin = 1'b0;
    wait_until(c0 + 6); tin = 1'b1;
    wait_until(c0 + 9);
    rd(1, v); chk(v == 0, "R8 count after two pin edges", v, 0);

    // gate
    tin = 1'b0;
    wr(5, 8'h05); wr(3, 3); wr(4, 8'h0C);
    repeat (20) @(negedge clk);
    rd(1, v); chk(v == 3, "R9 gate closed holds count", v, 3);
    c0 = cyc;
    tin = 1'b1;
    e1 = nth4(c0 + 2, 3);
    push(1, e1, "R9");
    wait_until(e1 + 2);

    // single trigger
    wr(5, 8'h06); wr(3, 5); wr(4, 8'h08);
    c0 = cyc;
    tin = 1'b0;
    e1 = nth4(c0 + 3, 5);
    push(1, e1, "R10");
    wait_until(c0 + 2); tin = 1'b1;
    wait_until(c0 + 8); tin = 1'b0;
    wait_until(c0 + 10); tin = 1'b1;
    wait_until(e1 + 2);
    rd(1, v); chk(v == 0, "R10 second edge ignored", v, 0);
    c1 = cyc;
    tin = 1'b0;
    e2 = nth4(c1 + 3, 5);
    push(1, e2, "R10 rearmed");
    wait_until(c1 + 2); tin = 1'b1;
    wait_until(e2 + 2);

    // retriggerable
    wr(5, 8'h07);
    c0 = cyc;
    tin = 1'b0;
    wait_until(c0 + 2); tin = 1'b1;
    wait_until(c0 + 8); tin = 1'b0;
    c1 = cyc;
    e1 = nth4(c1 + 3, 5);
    push(1, e1, "R11");
    wait_until(c1 + 2); tin = 1'b1;
    wait_until(c1 + 3);
    rd(1, v); chk(v == 5, "R11 reload on second edge", v, 5);
    wait_until(e1 + 2);
    wr(4, 0);

    // cascade
    wr(5, 8'h08);
    wr(0, 8'h41); wr(1, 3); wr(2, 8'h41); wr(3, 2); wr(4, 8'h0F); cw = last_wr;
    for (int k = 1; k <= 4; k++) push(0, cw + 3 * k, "R12");
    push(1, cw + 6, "R12"); push(1, cw + 12, "R12");
    wait_until(cw + 12);
    wr(4, 0);

    // reference on output pin
    wr(5, 8'h30);
    highs = 0;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      if (tout) highs++;
    end
    chk(highs == 4, "R14 reference duty", highs, 4);
    wr(5, 8'h00);
    repeat (3) @(negedge clk);
    chk(tout == 1'b0, "R14 output off", int'(tout), 0);

    repeat (5) @(negedge clk);
    chk(q0.size() == 0, "R13 irq0 all seen", q0.size(), 0);
    chk(q1.size() == 0, "R13 irq1 all seen", q1.size(), 0);
    finish_run();
  end
endmodule